// File: doc/BRIEF.md
# LCD Pixel Palette and Bypass Router

This block sits between the frame-buffer pixel stream and the panel output stage. Each incoming pixel word takes one of three routes, picked by the active depth mode:
- At 1, 2, 4 or 8 bits per pixel the word indexes a 256-entry by 12-bit colour palette, and the entry read out goes to the dither stage.
- At 12 bits per pixel the word skips the palette and goes to the dither stage as it is.
- At 16 bits per pixel the word skips both the palette and the dither stage and leaves on a raw output meant for the panel pins.

Software fills the palette through a dedicated write port. Software also writes a mode word into a staging register. The route in use changes only when a frame-start pulse arrives, so a frame never mixes depths.

The palette read is synchronous and takes one cycle. The bypass routes are delayed by one matching register, so every mode has a latency of exactly one cycle and pixels leave in the order they arrived. A grey option sends only the low four bits of the palette entry onward, which gives 16 grey levels. Pixels stream with a valid flag only; there is no backpressure.

Top module: `lcd_pixel_route`

## Requirements
- R1: After reset both output valid flags and both data outputs are zero, and the active mode is 8 bits per pixel with colour output (grey off).
- R2: A palette write with `pal_we_i` high stores `pal_wdata_i` at `pal_waddr_i`, and later palette lookups of that index return the stored value.
- R3: Depth codes 0, 1, 2 and 3 in `mode_wdata_i[2:0]` select 1, 2, 4 and 8 bits per pixel. The palette index is the low 1, 2, 4 or 8 pixel bits, zero-extended to 8 bits; all higher pixel bits are ignored.
- R4: Depth code 4 selects 12 bits per pixel. `col_o` carries `pix_data_i[11:0]`, and pixel bits 15:12 are ignored.
- R5: Depth code 5 selects 16 bits per pixel. `raw_valid_o` is raised, `raw_o` carries the whole pixel, and `col_valid_o` stays low.
- R6: A pixel accepted on a clock edge appears on exactly one output one edge later, in every mode. Back-to-back pixels leave in arrival order, and a cycle with no input valid gives no output valid.
- R7: When a palette write and a lookup of the same entry happen on the same edge, the lookup returns the value held before the write.
- R8: A mode write lands in a staging register. The active mode loads the staged value only on an edge where `frame_start_i` is high, and a pixel accepted on that same edge still uses the old mode.
- R9: Grey option (`mode_wdata_i[3]` = 1) on the palette routes makes `col_o` equal to the low 4 bits of the palette entry, with zeros above. It has no effect at 12 or 16 bits per pixel.
- R10: A mode write with depth code 6 or 7 is ignored, and the staged mode keeps its old value.
- R11: When a valid flag is low, its data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Write strobe for the staged mode |
| mode_wdata_i | input | 4 | Bit 3 grey option, bits 2:0 depth code |
| frame_start_i | input | 1 | Frame-start pulse; makes the staged mode active |
| pal_we_i | input | 1 | Palette write strobe |
| pal_waddr_i | input | 8 | Palette write index |
| pal_wdata_i | input | 12 | Palette write data |
| pix_valid_i | input | 1 | Pixel input valid |
| pix_data_i | input | 16 | Pixel input word |
| col_valid_o | output | 1 | Colour output to the dither stage is valid |
| col_o | output | 12 | Colour value to the dither stage |
| raw_valid_o | output | 1 | Raw output to the pins is valid |
| raw_o | output | 16 | Raw pixel to the pins |

## Verification
The bench goes after the corners of this block where a faulty design fails:
- Pixel bits above the depth width are set. A design that does not mask them indexes the wrong palette entry.
- A palette write and a lookup of the same entry fall on one edge. A write-first memory returns the new colour a cycle early.
- The staged mode is written with no frame-start pulse, or a pixel arrives in the same cycle as the pulse. A design that applies the mode at once switches routes in the middle of a frame.
- A reserved depth code is written, and back-to-back pixels are sent in a bypass mode. A design that lets the code through sends pixels down an undefined route. A design with unaligned bypass timing shows gaps or duplicated pixels.

// File: rtl/lcd_pix_pkg.sv
package lcd_pix_pkg;

  typedef enum logic [2:0] {
    DEP_1  = 3'd0,
    DEP_2  = 3'd1,
    DEP_4  = 3'd2,
    DEP_8  = 3'd3,
    DEP_12 = 3'd4,
    DEP_16 = 3'd5
  } depth_e;

  typedef struct packed {
    logic   grey;
    depth_e depth;
  } mode_t;

  typedef enum logic [1:0] {
    RT_PAL  = 2'd0,
    RT_DITH = 2'd1,
    RT_RAW  = 2'd2
  } route_e;

  localparam mode_t MODE_RST = '{grey: 1'b0, depth: DEP_8};

  function automatic int depth_bits(depth_e d);
    case (d)
      DEP_1:   return 1;
      DEP_2:   return 2;
      DEP_4:   return 4;
      DEP_8:   return 8;
      DEP_12:  return 12;
      default: return 16;
    endcase
  endfunction

  function automatic route_e route_of(depth_e d);
    case (d)
      DEP_12:  return RT_DITH;
      DEP_16:  return RT_RAW;
      default: return RT_PAL;
    endcase
  endfunction

  function automatic logic depth_legal(logic [2:0] code);
    return code <= 3'd5;
  endfunction

endpackage

// File: rtl/lcd_pix_mode.sv
module lcd_pix_mode
  import lcd_pix_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [3:0] wdata_i,
  input  logic       frame_start_i,
  output mode_t      pending_o,
  output mode_t      active_o
);

  mode_t pending_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= MODE_RST;
      active_q  <= MODE_RST;
    end else begin
      // reserved depth codes are dropped
      if (we_i && depth_legal(wdata_i[2:0])) begin
        pending_q.grey  <= wdata_i[3];
        pending_q.depth <= depth_e'(wdata_i[2:0]);
      end
      if (frame_start_i) active_q <= pending_q;
    end
  end

  assign pending_o = pending_q;
  assign active_o  = active_q;

endmodule

// File: rtl/lcd_pix_index.sv
module lcd_pix_index
  import lcd_pix_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  depth_e             depth_i,
  input  logic [IDX_W-1:0]   pix_i,
  output logic [IDX_W-1:0]   idx_o
);

  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    assign idx_o[b] = pix_i[b] & (b < depth_bits(depth_i));
  end

endmodule

// File: rtl/lcd_pal_ram.sv
module lcd_pal_ram #(
  parameter int AW = 8,
  parameter int DW = 12,
  localparam int ENTRIES = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [ENTRIES];
  logic [DW-1:0] rd_q;

  // read-first: same-edge write is not visible to the read
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;

endmodule

// File: rtl/lcd_pixel_route.sv
module lcd_pixel_route
  import lcd_pix_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COL_W  = 12,
  parameter int RAW_W  = 16,
  parameter int GREY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic [3:0]       mode_wdata_i,
  input  logic             frame_start_i,
  input  logic             pal_we_i,
  input  logic [IDX_W-1:0] pal_waddr_i,
  input  logic [COL_W-1:0] pal_wdata_i,
  input  logic             pix_valid_i,
  input  logic [RAW_W-1:0] pix_data_i,
  output logic             col_valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             raw_valid_o,
  output logic [RAW_W-1:0] raw_o
);

  mode_t pending_mode, active_mode;
  logic [IDX_W-1:0] pal_idx;
  logic [COL_W-1:0] pal_rd;

  lcd_pix_mode u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (mode_we_i),
    .wdata_i      (mode_wdata_i),
    .frame_start_i(frame_start_i),
    .pending_o    (pending_mode),
    .active_o     (active_mode)
  );

  lcd_pix_index #(.IDX_W(IDX_W)) u_index (
    .depth_i(active_mode.depth),
    .pix_i  (pix_data_i[IDX_W-1:0]),
    .idx_o  (pal_idx)
  );

  route_e route_in;
  assign route_in = route_of(active_mode.depth);

  lcd_pal_ram #(.AW(IDX_W), .DW(COL_W)) u_pal (
    .clk_i  (clk_i),
    .we_i   (pal_we_i),
    .waddr_i(pal_waddr_i),
    .wdata_i(pal_wdata_i),
    .re_i   (pix_valid_i && route_in == RT_PAL),
    .raddr_i(pal_idx),
    .rdata_o(pal_rd)
  );

  // bypass alignment stage, one cycle to match the palette read
  logic             v_q;
  route_e           route_q;
  logic             grey_q;
  logic [RAW_W-1:0] pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q     <= 1'b0;
      route_q <= RT_PAL;
      grey_q  <= 1'b0;
      pix_q   <= '0;
    end else begin
      v_q <= pix_valid_i;
      if (pix_valid_i) begin
        route_q <= route_in;
        grey_q  <= active_mode.grey;
        pix_q   <= pix_data_i;
      end
    end
  end

  logic [COL_W-1:0] col_pal, col_sel;

  always_comb begin
    if (grey_q) col_pal = {{(COL_W-GREY_W){1'b0}}, pal_rd[GREY_W-1:0]};
    else        col_pal = pal_rd;
    col_sel = (route_q == RT_PAL) ? col_pal : pix_q[COL_W-1:0];
  end

  assign col_valid_o = v_q && route_q != RT_RAW;
  assign raw_valid_o = v_q && route_q == RT_RAW;
  assign col_o       = col_valid_o ? col_sel : '0;
  assign raw_o       = raw_valid_o ? pix_q : '0;

endmodule

// File: rtl/lcd_pixel_route_chk.sv
module lcd_pixel_route_chk
  import lcd_pix_pkg::*;
#(
  parameter int COL_W = 12,
  parameter int RAW_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_we_i,
  input logic [3:0]       mode_wdata_i,
  input logic             frame_start_i,
  input logic             pix_valid_i,
  input logic [RAW_W-1:0] pix_data_i,
  input logic             col_valid_o,
  input logic [COL_W-1:0] col_o,
  input logic             raw_valid_o,
  input logic [RAW_W-1:0] raw_o,
  input mode_t            pending_mode,
  input mode_t            active_mode
);

  assert_valid_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o || raw_valid_o) == $past(pix_valid_i));

  assert_raw_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_valid_o |-> raw_o == $past(pix_data_i));

  assert_dith_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && $past(active_mode.depth == DEP_12)) |-> col_o == $past(pix_data_i[COL_W-1:0]));

  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(active_mode));

  assert_bad_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && mode_wdata_i[2:0] > 3'd5) |=> $stable(pending_mode));

endmodule

bind lcd_pixel_route lcd_pixel_route_chk #(.COL_W(COL_W), .RAW_W(RAW_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_we_i    (mode_we_i),
  .mode_wdata_i (mode_wdata_i),
  .frame_start_i(frame_start_i),
  .pix_valid_i  (pix_valid_i),
  .pix_data_i   (pix_data_i),
  .col_valid_o  (col_valid_o),
  .col_o        (col_o),
  .raw_valid_o  (raw_valid_o),
  .raw_o        (raw_o),
  .pending_mode (pending_mode),
  .active_mode  (active_mode)
);

// File: tb/lcd_pixel_route_test.sv
`timescale 1ns/1ps
module lcd_pixel_route_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_we_i = 1'b0;
  logic [3:0]  mode_wdata_i = '0;
  logic        frame_start_i = 1'b0;
  logic        pal_we_i = 1'b0;
  logic [7:0]  pal_waddr_i = '0;
  logic [11:0] pal_wdata_i = '0;
  logic        pix_valid_i = 1'b0;
  logic [15:0] pix_data_i = '0;
  logic        col_valid_o, raw_valid_o;
  logic [11:0] col_o;
  logic [15:0] raw_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  lcd_pixel_route uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i), .frame_start_i(frame_start_i),
    .pal_we_i(pal_we_i), .pal_waddr_i(pal_waddr_i), .pal_wdata_i(pal_wdata_i),
    .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
    .col_valid_o(col_valid_o), .col_o(col_o),
    .raw_valid_o(raw_valid_o), .raw_o(raw_o)
  );

  function automatic logic [11:0] pal_val(input logic [7:0] i);
    return {~i[3:0], i[7:4], i[3:0] ^ 4'h6};
  endfunction

  function automatic logic [11:0] grey_val(input logic [7:0] i);
    logic [11:0] e;
    e = pal_val(i);
    return {8'h00, e[3:0]};
  endfunction

  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] pix;
    logic        cv;
    logic [11:0] col;
    logic        rv;
    logic [15:0] raw;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'h3, 16'h00A7, 1'b1, pal_val(8'hA7), 1'b0, 16'h0000, 4'd3},  // R3 8bpp
    '{4'h3, 16'hFF5C, 1'b1, pal_val(8'h5C), 1'b0, 16'h0000, 4'd3},  // R3 upper ignored
    '{4'h2, 16'h00F9, 1'b1, pal_val(8'h09), 1'b0, 16'h0000, 4'd3},  // R3 4bpp
    '{4'h1, 16'h0007, 1'b1, pal_val(8'h03), 1'b0, 16'h0000, 4'd3},  // R3 2bpp
    '{4'h0, 16'h00FE, 1'b1, pal_val(8'h00), 1'b0, 16'h0000, 4'd3},  // R3 1bpp
    '{4'h0, 16'h0003, 1'b1, pal_val(8'h01), 1'b0, 16'h0000, 4'd3},  // R3 1bpp
    '{4'h4, 16'hF123, 1'b1, 12'h123,        1'b0, 16'h0000, 4'd4},  // R4
    '{4'h5, 16'hBEEF, 1'b0, 12'h000,        1'b1, 16'hBEEF, 4'd5},  // R5, R11 col zero
    '{4'hB, 16'h0034, 1'b1, grey_val(8'h34),1'b0, 16'h0000, 4'd9},  // R9 grey 8bpp
    '{4'hC, 16'h0ABC, 1'b1, 12'hABC,        1'b0, 16'h0000, 4'd9},  // R9 no effect 12bpp
    '{4'hD, 16'h1234, 1'b0, 12'h000,        1'b1, 16'h1234, 4'd9},  // R9 no effect 16bpp
    '{4'hA, 16'h001E, 1'b1, grey_val(8'h0E),1'b0, 16'h0000, 4'd9}   // R9 grey 4bpp
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic cv, input logic [11:0] col,
                           input logic rv, input logic [15:0] raw);
    check(req, {31'd0, col_valid_o}, {31'd0, cv});
    check(req, {20'd0, col_o}, {20'd0, col});
    check(req, {31'd0, raw_valid_o}, {31'd0, rv});
    check(req, {16'd0, raw_o}, {16'd0, raw});
  endtask

  // called at a negedge, returns at a negedge
  task automatic stage_mode(input logic [3:0] m);
    mode_we_i = 1'b1; mode_wdata_i = m;
    @(posedge clk); @(negedge clk);
    mode_we_i = 1'b0;
  endtask

  task automatic pulse_frame();
    frame_start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    frame_start_i = 1'b0;
  endtask

  task automatic send_pix(input logic [15:0] p);
    pix_valid_i = 1'b1; pix_data_i = p;
    @(posedge clk); @(negedge clk);
    pix_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_out("R1 reset", 1'b0, 12'h000, 1'b0, 16'h0000);

    // R2: fill palette
    for (int i = 0; i < 256; i++) begin
      pal_we_i = 1'b1; pal_waddr_i = 8'(i); pal_wdata_i = pal_val(8'(i));
      @(posedge clk); @(negedge clk);
    end
    pal_we_i = 1'b0;

    // R1: default mode is 8bpp colour
    send_pix(16'h0042);
    check_out("R1 default mode", 1'b1, pal_val(8'h42), 1'b0, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      stage_mode(VEC[k].mode);
      pulse_frame();
      send_pix(VEC[k].pix);
      check_out($sformatf("R%0d vec%0d", VEC[k].req, k), VEC[k].cv, VEC[k].col, VEC[k].rv, VEC[k].raw);
    end

    // R8: staged 16bpp not active without frame start (active is grey 4bpp)
    stage_mode(4'h5);
    send_pix(16'h0003);
    check_out("R8 staged only", 1'b1, grey_val(8'h03), 1'b0, 16'h0000);
    // R8: pixel on frame-start edge uses old mode
    frame_start_i = 1'b1; pix_valid_i = 1'b1; pix_data_i = 16'h0004;
    @(posedge clk); @(negedge clk);
    frame_start_i = 1'b0; pix_valid_i = 1'b0;
    check_out("R8 same edge", 1'b1, grey_val(8'h04), 1'b0, 16'h0000);
    send_pix(16'h0004);
    check_out("R8 after frame", 1'b0, 12'h000, 1'b1, 16'h0004);

    // R10: reserved codes ignored
    stage_mode(4'h7);
    stage_mode(4'hE);
    pulse_frame();
    send_pix(16'h5555);
    check_out("R10 reserved", 1'b0, 12'h000, 1'b1, 16'h5555);

    // R6: back-to-back in 12bpp with a bubble
    stage_mode(4'h4);
    pulse_frame();
    pix_valid_i = 1'b1; pix_data_i = 16'h0111;
    @(posedge clk); @(negedge clk);
    check_out("R6 first", 1'b1, 12'h111, 1'b0, 16'h0000);
    pix_data_i = 16'h0222;
    @(posedge clk); @(negedge clk);
    check_out("R6 second", 1'b1, 12'h222, 1'b0, 16'h0000);
    pix_valid_i = 1'b0;
    @(posedge clk); @(negedge clk);
    check_out("R6 bubble R11", 1'b0, 12'h000, 1'b0, 16'h0000);
    // R6: back-to-back in 16bpp
    stage_mode(4'h5);
    pulse_frame();
    pix_valid_i = 1'b1; pix_data_i = 16'hA001;
    @(posedge clk); @(negedge clk);
    check_out("R6 raw first", 1'b0, 12'h000, 1'b1, 16'hA001);
    pix_data_i = 16'hA002;
    @(posedge clk); @(negedge clk);
    pix_valid_i = 1'b0;
    check_out("R6 raw second", 1'b0, 12'h000, 1'b1, 16'hA002);

    // R7: same-edge write and read of entry 0x20 returns old value
    stage_mode(4'h3);
    pulse_frame();
    pal_we_i = 1'b1; pal_waddr_i = 8'h20; pal_wdata_i = 12'hABC;
    pix_valid_i = 1'b1; pix_data_i = 16'h0020;
    @(posedge clk); @(negedge clk);
    pal_we_i = 1'b0; pix_valid_i = 1'b0;
    check_out("R7 old value", 1'b1, pal_val(8'h20), 1'b0, 16'h0000);
    send_pix(16'h0020);
    check_out("R2 R7 new value", 1'b1, 12'hABC, 1'b0, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule